// File: doc/BRIEF.md
# Hidden-Refresh Pseudo-SRAM Controller

This block puts a DRAM row array behind a plain SRAM-style request port. The host selects the memory, gives a write enable, an address and write data, and either stores a word or reads one back. It never schedules refresh and never issues a refresh command. Inside the block, an interval timer decides when the next row is due. A row pointer walks through the array one row at a time. An arbiter keeps refresh away from host traffic.

The refresh rate follows a power-mode input. In active mode the whole array is refreshed once every 64 ms. Each of the two standby levels stretches that period to a value taken from a configuration input, given in milliseconds. Time is scaled by a parameter giving clock cycles per millisecond. A refresh that falls due while the host holds the chip selected is only counted. Counted refreshes are then issued back to back once the host lets go. A host request that lands on a running refresh is held off with the wait signal and is served afterwards.

Top module: `hidden_refresh_sram`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy` is 0, `rf_stb` is 0 and `rdata` is 0.
- R2: An access is accepted in a cycle where `cs` is 1 and `busy` is 0. With `we`=1 it stores `wdata` at `addr`. With `we`=0 it loads the word at `addr` into `rdata` at that clock edge, and `rdata` holds it until the next accepted read.
- R3: In active mode (`pwr_mode`=00) with the host idle, successive `rf_stb` pulses are exactly 64*CYC_PER_MS/ROWS cycles apart.
- R4: Each `rf_stb` pulse refreshes the row on `rf_row`. `rf_row` then steps by one, going from ROWS-1 back to 0 (ROWS is a power of two).
- R5: In light standby (`pwr_mode`=01) the row interval is cfg_light_ms*CYC_PER_MS/ROWS cycles.
- R6: In deep standby (`pwr_mode`=10 or 11) the row interval uses the larger of cfg_light_ms and cfg_deep_ms. A programmed period above 500 ms is used as given, with no clamp.
- R7: A change of mode or configuration takes effect only when the running interval expires. The interval in progress finishes with its old length.
- R8: No refresh starts in a cycle where `cs` is 1. Each interval that expires during that time adds one to a pending count.
- R9: Once `cs` is 0, pending refreshes are issued back to back, one every RF_CYC+1 cycles, and none is lost. The pending count saturates at MAX_PEND.
- R10: A refresh keeps `busy` at 1 for RF_CYC cycles after its strobe. A host request held during that time is completed after `busy` falls, without loss of data.
- R11: With short host holds, no row goes longer between refreshes than ROWS times the longest interval in use, plus a small deferral allowance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Host select; holding it high marks an access in progress |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word address, row in the upper bits |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| busy | output | 1 | Wait: a row refresh is running |
| pwr_mode | input | 2 | 00 active, 01 light standby, 10/11 deep standby |
| cfg_light_ms | input | MSW | Light-standby full-array period in ms |
| cfg_deep_ms | input | MSW | Deep-standby full-array period in ms |
| rf_stb | output | 1 | One-cycle pulse at the start of a row refresh |
| rf_row | output | RB | Row refreshed when rf_stb is high |

## Verification
The scheduler is driven with an idle host in each of the three modes, so the measured strobe spacing tells active, light and deep intervals apart. A deep setting below the light one shows that the larger period wins. Mode and configuration changes are made just after a strobe, which separates a reload at the boundary (one more old-length gap) from an immediate reload. Host holds of two and six intervals tell counted deferral apart from saturation. A request placed right after a strobe measures the stall length and checks that the write survives.

// File: rtl/rh_pkg.sv
`timescale 1ns/1ps
package rh_pkg;
    typedef enum logic [1:0] {
        PM_ACTIVE   = 2'b00,
        PM_LIGHT    = 2'b01,
        PM_DEEP     = 2'b10,
        PM_DEEP_ALT = 2'b11
    } pmode_e;
endpackage

// File: rtl/rh_interval.sv
`timescale 1ns/1ps
module rh_interval #(
    parameter int NOM_MS     = 64,
    parameter int CYC_PER_MS = 16,
    parameter int RB         = 3,
    parameter int MSW        = 10,
    parameter int TW         = 16
) (
    input  logic [1:0]     mode,
    input  logic [MSW-1:0] cfg_light_ms,
    input  logic [MSW-1:0] cfg_deep_ms,
    output logic [TW-1:0]  intv
);
    import rh_pkg::*;

    localparam logic [TW-1:0] ACT_INT = TW'((NOM_MS * CYC_PER_MS) >> RB);

    logic [MSW-1:0] deep_ms;
    logic [TW-1:0]  light_cyc;
    logic [TW-1:0]  deep_cyc;
    logic [TW-1:0]  pick;

    always_comb begin
        deep_ms   = (cfg_deep_ms > cfg_light_ms) ? cfg_deep_ms : cfg_light_ms;
        light_cyc = (TW'(cfg_light_ms) * TW'(CYC_PER_MS)) >> RB;
        deep_cyc  = (TW'(deep_ms) * TW'(CYC_PER_MS)) >> RB;
        case (pmode_e'(mode))
            PM_ACTIVE: pick = ACT_INT;
            PM_LIGHT:  pick = light_cyc;
            default:   pick = deep_cyc;
        endcase
        intv = (pick == '0) ? TW'(1) : pick;
    end
endmodule

// File: rtl/rh_sched.sv
`timescale 1ns/1ps
module rh_sched #(
    parameter int TW       = 16,
    parameter int RB       = 3,
    parameter int RF_CYC   = 4,
    parameter int MAX_PEND = 3,
    parameter int RST_INT  = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic [TW-1:0] intv,
    output logic          busy,
    output logic          rf_stb,
    output logic [RB-1:0] rf_row
);
    localparam int PW = $clog2(MAX_PEND + 1);
    localparam int CW = $clog2(RF_CYC + 1);

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic [PW-1:0] pend;
        logic          act;
        logic [CW-1:0] cnt;
        logic [RB-1:0] row;
    } st_t;

    st_t  st_d, st_q;
    logic expire;
    logic start;

    always_comb begin
        st_d   = st_q;
        expire = (st_q.tmr == '0);
        start  = !cs && !st_q.act && (st_q.pend != '0);

        if (expire) st_d.tmr = intv - 1'b1;
        else        st_d.tmr = st_q.tmr - 1'b1;

        case ({expire, start})
            2'b10: if (st_q.pend != PW'(MAX_PEND)) st_d.pend = st_q.pend + 1'b1;
            2'b01: st_d.pend = st_q.pend - 1'b1;
            default: st_d.pend = st_q.pend;
        endcase

        if (start) begin
            st_d.act = 1'b1;
            st_d.cnt = CW'(RF_CYC - 1);
            st_d.row = st_q.row + 1'b1;
        end else if (st_q.act) begin
            if (st_q.cnt == '0) st_d.act = 1'b0;
            else                st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.tmr  <= TW'(RST_INT - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.act;
    assign rf_stb = start;
    assign rf_row = st_q.row;

    // R8: refresh never starts while the host holds select
    p_no_refresh_under_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_stb |-> !cs);
    // R10: a refresh strobe is followed by the wait signal
    p_busy_after_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rf_stb |=> busy);
    // R9: refreshes never overlap
    p_single_refresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_stb |-> !busy);
    // R4: row pointer steps by one per strobe
    p_row_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_stb |=> (rf_row == RB'($past(rf_row) + 1'b1)));
    // R7: timer only reloads when it reaches zero
    p_timer_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tmr != '0) |=> (st_q.tmr == TW'($past(st_q.tmr) - 1'b1)));
    // R9: pending count saturates instead of wrapping
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend == PW'(MAX_PEND)) |=> (st_q.pend >= PW'(MAX_PEND - 1)));
endmodule

// File: rtl/rh_array.sv
`timescale 1ns/1ps
module rh_array #(
    parameter int ROWS = 8,
    parameter int COLS = 4,
    parameter int DW   = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               acc,
    input  logic                               we,
    input  logic [$clog2(ROWS*COLS)-1:0]       addr,
    input  logic [DW-1:0]                      wdata,
    input  logic                               rf_stb,
    input  logic [$clog2(ROWS)-1:0]            rf_row,
    output logic [DW-1:0]                      rdata
);
    localparam int DEPTH = ROWS * COLS;
    localparam int CB    = $clog2(COLS);

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (acc && !we) rdata_d = mem[addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    // behavioural array: a refresh restores every word of the strobed row
    always_ff @(posedge clk) begin
        if (acc && we) begin
            mem[addr] <= wdata;
        end else if (rf_stb) begin
            for (int c = 0; c < COLS; c++)
                mem[{rf_row, CB'(c)}] <= mem[{rf_row, CB'(c)}];
        end
    end

    assign rdata = rdata_q;

    // R10: host access and row refresh never share a cycle
    p_acc_vs_refresh_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> !rf_stb);
endmodule

// File: rtl/hidden_refresh_sram.sv
`timescale 1ns/1ps
module hidden_refresh_sram #(
    parameter int ROWS       = 8,
    parameter int COLS       = 4,
    parameter int DW         = 8,
    parameter int CYC_PER_MS = 16,
    parameter int NOM_MS     = 64,
    parameter int MSW        = 10,
    parameter int RF_CYC     = 4,
    parameter int MAX_PEND   = 3,
    parameter int AW         = $clog2(ROWS * COLS),
    parameter int RB         = $clog2(ROWS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs,
    input  logic           we,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic           busy,
    input  logic [1:0]     pwr_mode,
    input  logic [MSW-1:0] cfg_light_ms,
    input  logic [MSW-1:0] cfg_deep_ms,
    output logic           rf_stb,
    output logic [RB-1:0]  rf_row
);
    localparam int TW      = MSW + $clog2(CYC_PER_MS + 1) + 1;
    localparam int RST_INT = (NOM_MS * CYC_PER_MS) >> RB;

    logic [TW-1:0] intv;
    logic          acc;

    rh_interval #(
        .NOM_MS(NOM_MS), .CYC_PER_MS(CYC_PER_MS), .RB(RB), .MSW(MSW), .TW(TW)
    ) u_intv (
        .mode(pwr_mode), .cfg_light_ms(cfg_light_ms), .cfg_deep_ms(cfg_deep_ms),
        .intv(intv)
    );

    rh_sched #(
        .TW(TW), .RB(RB), .RF_CYC(RF_CYC), .MAX_PEND(MAX_PEND), .RST_INT(RST_INT)
    ) u_sched (
        .clk(clk), .rst_n(rst_n), .cs(cs), .intv(intv),
        .busy(busy), .rf_stb(rf_stb), .rf_row(rf_row)
    );

    assign acc = cs && !busy;

    rh_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_array (
        .clk(clk), .rst_n(rst_n), .acc(acc), .we(we), .addr(addr),
        .wdata(wdata), .rf_stb(rf_stb), .rf_row(rf_row), .rdata(rdata)
    );
endmodule

// File: tb/sim_hidden_refresh_sram.sv
`timescale 1ns/1ps
module sim_hidden_refresh_sram;
    localparam int ROWS = 8, COLS = 4, DW = 8, CPM = 16, MSW = 10, RF_CYC = 4;
    localparam int AW = $clog2(ROWS * COLS), RB = $clog2(ROWS);
    localparam int ACT_I = 64 * CPM / ROWS;      // 128
    localparam int LGT_I = 150 * CPM / ROWS;     // 300
    localparam int DEP_I = 520 * CPM / ROWS;     // 1040
    localparam longint GAP_LIMIT = ROWS * DEP_I + 1000;

    logic clk = 0, rst_n = 0, cs = 0, we = 0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic busy, rf_stb;
    logic [1:0] pwr_mode = 2'b00;
    logic [MSW-1:0] cfg_light_ms = 10'd150, cfg_deep_ms = 10'd520;
    logic [RB-1:0] rf_row;

    int nchk = 0, nfail = 0;
    longint cyc = 0;
    longint last_seen [ROWS];
    int gap_viol = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hidden_refresh_sram #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .CYC_PER_MS(CPM),
                          .MSW(MSW), .RF_CYC(RF_CYC), .MAX_PEND(3)) u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .busy(busy), .pwr_mode(pwr_mode), .cfg_light_ms(cfg_light_ms),
        .cfg_deep_ms(cfg_deep_ms), .rf_stb(rf_stb), .rf_row(rf_row));

    // R11 monitor: per-row refresh gap
    initial for (int i = 0; i < ROWS; i++) last_seen[i] = -1;
    always @(negedge clk) begin
        if (rst_n && rf_stb) begin
            if (last_seen[rf_row] >= 0 && (cyc - last_seen[rf_row]) > GAP_LIMIT) begin
                gap_viol++;
                $display("FAIL R11 row %0d gap: actual %0d expected <= %0d",
                         rf_row, cyc - last_seen[rf_row], GAP_LIMIT);
            end
            last_seen[rf_row] = cyc;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_stb(output longint at, output int row);
        @(negedge clk);
        while (!rf_stb) @(negedge clk);
        at = cyc;
        row = int'(rf_row);
    endtask

    task automatic host_access(input logic w, input logic [AW-1:0] a,
                               input logic [DW-1:0] d, output logic [DW-1:0] q,
                               output int waits);
        @(posedge clk); #1;
        cs = 1; we = w; addr = a; wdata = d; waits = 0;
        @(negedge clk);
        while (busy) begin waits++; @(negedge clk); end
        @(posedge clk); #1;
        cs = 0; we = 0;
        @(negedge clk);
        q = rdata;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 strobe in reset", rf_stb, 0);
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 rdata after reset", rdata, 0);
        chk("R1 strobe after reset", rf_stb, 0);
    endtask

    task automatic t_rw;
        logic [DW-1:0] q;
        int w;
        host_access(1, 5'd0, 8'h3C, q, w);
        host_access(1, 5'd31, 8'hC3, q, w);
        host_access(1, 5'd10, 8'hFF, q, w);
        host_access(1, 5'd17, 8'h00, q, w);
        host_access(0, 5'd0, 8'h00, q, w);  chk("R2 read addr0", q, 8'h3C);
        host_access(0, 5'd31, 8'h00, q, w); chk("R2 read addr31", q, 8'hC3);
        host_access(0, 5'd10, 8'h00, q, w); chk("R2 read addr10", q, 8'hFF);
        host_access(0, 5'd17, 8'h00, q, w); chk("R2 read addr17", q, 8'h00);
        repeat (3) @(negedge clk);
        chk("R2 rdata held", rdata, 8'h00);
    endtask

    task automatic t_active;
        longint t0, t1;
        int r0, r1;
        bit wrapped = 0;
        wait_stb(t0, r0);
        for (int k = 0; k < ROWS + 1; k++) begin
            wait_stb(t1, r1);
            if (k < 2) chk("R3 active gap", t1 - t0, ACT_I);
            chk("R4 row order", r1, (r0 + 1) % ROWS);
            if (r1 == 0) wrapped = 1;
            t0 = t1; r0 = r1;
        end
        chk("R4 row wrap seen", wrapped, 1);
    endtask

    task automatic t_light_deep;
        longint t0, t1;
        int r;
        wait_stb(t0, r);
        repeat (3) @(posedge clk); #1 pwr_mode = 2'b01;
        wait_stb(t1, r); chk("R7 old gap kept on light entry", t1 - t0, ACT_I); t0 = t1;
        wait_stb(t1, r); chk("R5 light gap", t1 - t0, LGT_I); t0 = t1;
        repeat (3) @(posedge clk); #1 pwr_mode = 2'b10;
        wait_stb(t1, r); chk("R7 old gap kept on deep entry", t1 - t0, LGT_I); t0 = t1;
        wait_stb(t1, r); chk("R6 deep gap above 500ms", t1 - t0, DEP_I); t0 = t1;
        repeat (3) @(posedge clk); #1 cfg_deep_ms = 10'd100;
        wait_stb(t1, r); chk("R7 old gap kept on cfg change", t1 - t0, DEP_I); t0 = t1;
        wait_stb(t1, r); chk("R6 deep uses larger period", t1 - t0, LGT_I); t0 = t1;
        repeat (3) @(posedge clk); #1 begin pwr_mode = 2'b00; cfg_deep_ms = 10'd520; end
        wait_stb(t1, r); chk("R7 old gap kept on wake", t1 - t0, LGT_I); t0 = t1;
        wait_stb(t1, r); chk("R3 active gap after wake", t1 - t0, ACT_I);
    endtask

    task automatic t_defer(input int hold, input int exp_n, input string tag);
        longint t0, first;
        int r, n;
        longint sp;
        wait_stb(t0, r);
        @(posedge clk); #1 begin cs = 1; we = 0; addr = '0; end
        n = 0;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (rf_stb) n++;
        end
        chk({"R8 no refresh under cs ", tag}, n, 0);
        @(posedge clk); #1 cs = 0;
        n = 0; first = -1; sp = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (rf_stb) begin
                n++;
                if (n == 1) first = cyc;
                if (n == 2) sp = cyc - first;
            end
        end
        chk({"R9 deferred count ", tag}, n, exp_n);
        chk({"R9 back-to-back spacing ", tag}, sp, RF_CYC + 1);
    endtask

    task automatic t_stall;
        longint t0;
        int r, w;
        logic [DW-1:0] q;
        wait_stb(t0, r);
        host_access(1, 5'd5, 8'hA5, q, w);
        chk("R10 stall length", w, RF_CYC);
        host_access(0, 5'd5, 8'h00, q, w);
        chk("R10 stalled write kept", q, 8'hA5);
    endtask

    initial begin
        t_reset();
        t_rw();
        t_active();
        t_light_deep();
        t_defer(300, 2, "two intervals");
        t_defer(800, 3, "saturated");
        t_stall();
        chk("R11 rows over gap limit", gap_viol, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule